// File: doc/BRIEF.md
# Block-Cipher Feedback Mode Datapath

This block sits between a block-cipher core and the sequencer that drives it, and applies the chaining mode around each 64-bit block. It keeps a buffered input block, a buffered output block and a 64-bit chaining register (the initialization vector). From these it forms the word handed to the cipher core and the direction that core must run in. When the core returns its result, the block forms the final output word and advances the chaining register, so consecutive blocks chain with no further context writes.

Three modes are supported in both directions: electronic codebook (no chaining), cipher block chaining, and full 64-bit cipher feedback. The datapath sees only the first cipher input and the final cipher result of a block. A triple-pass operation, which runs the core three times with three keys under the sequencer's control, therefore chains exactly like a single pass. The cipher core and the key registers are outside this block.

Top module: `fbm_datapath`

## Requirements
- R1: After a synchronous active-low reset, `blk_full` and `out_valid` are 0 and `iv_out` is all zeros.
- R2: A `ctx_we` pulse loads `ctx_data` into the chaining register, and it is visible on `iv_out` in the next cycle. If `ctx_we` and `res_valid` arrive in the same cycle, the context write wins the chaining register, and the output word is still produced.
- R3: A `blk_load` pulse while `blk_full` is 0 captures `blk_data` and sets `blk_full` in the next cycle. A `blk_load` while `blk_full` is 1 is ignored, and the buffered block is kept.
- R4: `cfg_mode` 2'b00 selects codebook mode, and 2'b11 behaves the same way. In this mode `core_data` is the buffered block, `core_encrypt` follows `cfg_encrypt`, the output is the cipher result unchanged, and the chaining register does not change. Equal input blocks give equal outputs.
- R5: With `cfg_mode` 2'b01 (block chaining) and `cfg_encrypt`=1, `core_data` is the block XOR the chaining register. The output is the cipher result, and the cipher result becomes the new chaining value. Repeated plaintext blocks give distinct ciphertexts.
- R6: With `cfg_mode` 2'b01 and `cfg_encrypt`=0, `core_data` is the block and the core runs in decrypt. The output is the cipher result XOR the chaining register, and the incoming ciphertext block becomes the new chaining value.
- R7: With `cfg_mode` 2'b10 (cipher feedback), `core_data` is the chaining register and `core_encrypt` is 1 in both directions. The output is the block XOR the cipher result. The new chaining value is the ciphertext side: the output when encrypting, and the input block when decrypting.
- R8: A `res_valid` pulse makes `out_valid` 1 and clears `blk_full` in the next cycle, with `out_data` holding the formed output. `out_valid` and `out_data` then hold until `out_take`, unless a new result arrives first.
- R9: Blocks encrypted in sequence from one IV in block chaining or cipher feedback, then decrypted in sequence from the same IV, return the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Chaining mode: 00 codebook, 01 block chaining, 10 cipher feedback, 11 as 00 |
| cfg_encrypt | input | 1 | 1 encrypt, 0 decrypt |
| ctx_we | input | 1 | Write chaining register |
| ctx_data | input | 64 | Initialization vector for the chaining register |
| blk_load | input | 1 | Capture an input block |
| blk_data | input | 64 | Input block |
| blk_full | output | 1 | Input buffer holds a block |
| core_data | output | 64 | Word handed to the cipher core |
| core_encrypt | output | 1 | Direction the cipher core must run in |
| res_valid | input | 1 | Cipher core result available |
| res_data | input | 64 | Cipher core result |
| out_valid | output | 1 | Output buffer holds a finished block |
| out_data | output | 64 | Finished output block |
| out_take | input | 1 | Consume the output block |
| iv_out | output | 64 | Current chaining register value |

## Verification
The bench pairs the datapath with a simple invertible stand-in for the cipher core, and it predicts every cipher input, direction, output and chaining value from the mode equations. Repeated identical plaintext is sent through codebook mode, where the outputs must match, and through block chaining, where they must differ. This shows whether chaining is applied at all. Multi-block encrypt-then-decrypt sequences in block chaining and cipher feedback show whether the chaining register takes the ciphertext side in each direction, because a wrong source breaks recovery from the second block on. Loads into a full buffer, a context write in the same cycle as a result, and the reserved mode code cover the corner cases.

// File: rtl/fbm_pkg.sv
// Shared types for the feedback mode datapath.
package fbm_pkg;
    typedef enum logic [1:0] {
        MODE_ECB = 2'b00,
        MODE_CBC = 2'b01,
        MODE_CFB = 2'b10,
        MODE_RSV = 2'b11
    } fbm_mode_e;
endpackage

// File: rtl/fbm_chain_reg.sv
// Chaining register. It is loaded by a context write, or advanced after each
// completed block. Assumes ctx_we takes priority over a block update.
module fbm_chain_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctx_we,
    input  logic [W-1:0] ctx_data,
    input  logic         upd_en,
    input  logic [W-1:0] upd_data,
    output logic [W-1:0] chain
);
    // Holds the current chaining value.
    always_ff @(posedge clk) begin
        if (!rst_n)       chain <= '0;
        else if (ctx_we)  chain <= ctx_data;
        else if (upd_en)  chain <= upd_data;
    end

    a_r2_ctx_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_we |=> chain == $past(ctx_data));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_we && !upd_en |=> $stable(chain));
endmodule

// File: rtl/fbm_premix.sv
// Forms the word sent to the cipher core and the direction the core runs in.
// Assumes the mode and direction stay stable while a block is in flight.
module fbm_premix #(
    parameter int W = 64
) (
    input  fbm_pkg::fbm_mode_e mode,
    input  logic               enc,
    input  logic [W-1:0]       blk,
    input  logic [W-1:0]       chain,
    output logic [W-1:0]       core_word,
    output logic               core_enc
);
    import fbm_pkg::*;

    // Selects the cipher input per mode and direction.
    always_comb begin
        core_word = blk;
        core_enc  = enc;
        case (mode)
            MODE_CBC: if (enc) core_word = blk ^ chain;
            MODE_CFB: begin
                core_word = chain;
                core_enc  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbm_postmix.sv
// Forms the final output block and the next chaining value from the cipher
// result. Codebook mode leaves the chaining register unchanged.
module fbm_postmix #(
    parameter int W = 64
) (
    input  fbm_pkg::fbm_mode_e mode,
    input  logic               enc,
    input  logic [W-1:0]       blk,
    input  logic [W-1:0]       chain,
    input  logic [W-1:0]       res,
    output logic [W-1:0]       result,
    output logic [W-1:0]       next_chain,
    output logic               chains
);
    import fbm_pkg::*;

    // Output word and ciphertext-side chaining value per mode.
    always_comb begin
        result     = res;
        next_chain = chain;
        chains     = 1'b0;
        case (mode)
            MODE_CBC: begin
                chains = 1'b1;
                if (enc) begin
                    next_chain = res;
                end else begin
                    result     = res ^ chain;
                    next_chain = blk;
                end
            end
            MODE_CFB: begin
                chains     = 1'b1;
                result     = blk ^ res;
                next_chain = enc ? (blk ^ res) : blk;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbm_datapath.sv
// Feedback mode datapath: buffers one input and one output block, drives the
// cipher core input and direction, and advances the chaining register when
// the sequencer reports a result. Assumes res_valid comes only while a block
// is buffered.
module fbm_datapath #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_encrypt,
    input  logic         ctx_we,
    input  logic [W-1:0] ctx_data,
    input  logic         blk_load,
    input  logic [W-1:0] blk_data,
    output logic         blk_full,
    output logic [W-1:0] core_data,
    output logic         core_encrypt,
    input  logic         res_valid,
    input  logic [W-1:0] res_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_take,
    output logic [W-1:0] iv_out
);
    import fbm_pkg::*;

    fbm_mode_e    mode;
    logic [W-1:0] blk_buf;
    logic [W-1:0] result;
    logic [W-1:0] next_chain;
    logic         chains;

    assign mode = fbm_mode_e'(cfg_mode);

    // Input block buffer; a load into a full buffer is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_buf  <= '0;
            blk_full <= 1'b0;
        end else if (res_valid) begin
            blk_full <= 1'b0;
        end else if (blk_load && !blk_full) begin
            blk_buf  <= blk_data;
            blk_full <= 1'b1;
        end
    end

    // Output block buffer, held until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (res_valid) begin
            out_data  <= result;
            out_valid <= 1'b1;
        end else if (out_take) begin
            out_valid <= 1'b0;
        end
    end

    fbm_premix #(.W(W)) i_premix (
        .mode(mode), .enc(cfg_encrypt), .blk(blk_buf), .chain(iv_out),
        .core_word(core_data), .core_enc(core_encrypt)
    );

    fbm_postmix #(.W(W)) i_postmix (
        .mode(mode), .enc(cfg_encrypt), .blk(blk_buf), .chain(iv_out),
        .res(res_data), .result(result), .next_chain(next_chain), .chains(chains)
    );

    fbm_chain_reg #(.W(W)) i_chain (
        .clk(clk), .rst_n(rst_n), .ctx_we(ctx_we), .ctx_data(ctx_data),
        .upd_en(res_valid && chains), .upd_data(next_chain), .chain(iv_out)
    );

    a_r8_result_latched: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> out_valid && !blk_full);
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_take && !res_valid |=> out_valid && $stable(out_data));
    a_r3_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        blk_full && !res_valid |=> blk_full && $stable(blk_buf));
    a_r4_ecb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (cfg_mode == 2'b00 || cfg_mode == 2'b11) |=> out_data == $past(res_data));
    a_r7_cfb_forward: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode == 2'b10 |-> core_encrypt && core_data == iv_out);
endmodule

// File: tb/test_fbm_datapath.sv
module test_fbm_datapath;
    localparam int W = 64;
    localparam logic [W-1:0] KEY = 64'h0F1E_2D3C_4B5A_6978;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_mode = 2'b00;
    logic         cfg_encrypt = 1'b1;
    logic         ctx_we = 1'b0;
    logic [W-1:0] ctx_data = '0;
    logic         blk_load = 1'b0;
    logic [W-1:0] blk_data = '0;
    logic         blk_full;
    logic [W-1:0] core_data;
    logic         core_encrypt;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_take = 1'b0;
    logic [W-1:0] iv_out;

    int total = 0;
    int bad = 0;
    logic [W-1:0] m_chain;
    logic [W-1:0] pt [0:2];
    logic [W-1:0] ct [0:2];

    always #10 clk = ~clk;

    fbm_datapath #(.W(W)) i_fbm_datapath (.*);

    // Invertible stand-in cipher: rotate left by 7, then XOR the key.
    function automatic logic [W-1:0] toy(input logic [W-1:0] x, input logic e);
        logic [W-1:0] z;
        if (e) return {x[W-8:0], x[W-1:W-7]} ^ KEY;
        z = x ^ KEY;
        return {z[6:0], z[W-1:7]};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_iv(input logic [W-1:0] v);
        @(negedge clk); ctx_we = 1'b1; ctx_data = v;
        @(negedge clk); ctx_we = 1'b0;
        m_chain = v;
        chk(iv_out == v, "R2 iv load", iv_out, v);
    endtask

    // One block through the datapath, checked against the mode equations.
    task automatic run_block(input logic [1:0] md, input logic e, input logic [W-1:0] p, output logic [W-1:0] o);
        logic [W-1:0] cin, r, nc;
        logic ce;
        cfg_mode = md; cfg_encrypt = e;
        cin = p; ce = e; nc = m_chain;
        if (md == 2'b01 && e) cin = p ^ m_chain;
        if (md == 2'b10) begin cin = m_chain; ce = 1'b1; end
        r = toy(cin, ce);
        o = r;
        if (md == 2'b01) begin
            if (e) nc = r; else begin o = r ^ m_chain; nc = p; end
        end else if (md == 2'b10) begin
            o = p ^ r; nc = e ? o : p;
        end
        @(negedge clk); blk_load = 1'b1; blk_data = p;
        @(negedge clk); blk_load = 1'b0;
        chk(blk_full == 1'b1, "R3 full set", {63'd0, blk_full}, 64'd1);
        chk(core_data == cin, md == 2'b10 ? "R7 core input" : (md == 2'b01 ? (e ? "R5 core input" : "R6 core input") : "R4 core input"), core_data, cin);
        chk(core_encrypt == ce, md == 2'b10 ? "R7 core dir" : "R4 core dir", {63'd0, core_encrypt}, {63'd0, ce});
        res_valid = 1'b1; res_data = r;
        @(negedge clk); res_valid = 1'b0;
        chk(out_valid && !blk_full, "R8 result flags", {62'd0, out_valid, blk_full}, 64'd2);
        chk(out_data == o, md == 2'b10 ? "R7 output" : (md == 2'b01 ? (e ? "R5 output" : "R6 output") : "R4 output"), out_data, o);
        chk(iv_out == nc, md == 2'b10 ? "R7 chain" : (md == 2'b01 ? (e ? "R5 chain" : "R6 chain") : "R4 chain"), iv_out, nc);
        m_chain = nc;
        @(negedge clk);
        chk(out_valid && out_data == o, "R8 hold", out_data, o);
        out_take = 1'b1;
        @(negedge clk); out_take = 1'b0;
        chk(!out_valid, "R8 take", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] o1, o2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!blk_full && !out_valid && iv_out == '0, "R1 reset", iv_out, 64'd0);

        // R4 codebook: repeated block gives repeated output, chain untouched
        set_iv(64'h1234_5678_9ABC_DEF0);
        run_block(2'b00, 1'b1, 64'hAAAA_5555_0F0F_F0F0, o1);
        run_block(2'b00, 1'b1, 64'hAAAA_5555_0F0F_F0F0, o2);
        chk(o1 == o2, "R4 repeat equal", o2, o1);
        run_block(2'b11, 1'b0, 64'h0102_0304_0506_0708, o1);
        run_block(2'b00, 1'b0, 64'hFFFF_0000_FFFF_0000, o1);

        // R5/R9 block chaining encrypt then decrypt, repeated plaintext
        pt[0] = 64'h4E6F_7720_6973_2074; pt[1] = pt[0]; pt[2] = 64'h6865_2074_696D_6520;
        set_iv(64'h1234_5678_90AB_CDEF);
        for (int i = 0; i < 3; i++) run_block(2'b01, 1'b1, pt[i], ct[i]);
        chk(ct[0] != ct[1], "R5 repeat differs", ct[1], ct[0]);
        set_iv(64'h1234_5678_90AB_CDEF);
        for (int i = 0; i < 3; i++) begin
            run_block(2'b01, 1'b0, ct[i], o1);
            chk(o1 == pt[i], "R9 cbc recover", o1, pt[i]);
        end

        // R7/R9 cipher feedback encrypt then decrypt
        set_iv(64'hFEDC_BA98_7654_3210);
        for (int i = 0; i < 3; i++) run_block(2'b10, 1'b1, pt[i], ct[i]);
        chk(ct[0] != ct[1], "R7 repeat differs", ct[1], ct[0]);
        set_iv(64'hFEDC_BA98_7654_3210);
        for (int i = 0; i < 3; i++) begin
            run_block(2'b10, 1'b0, ct[i], o1);
            chk(o1 == pt[i], "R9 cfb recover", o1, pt[i]);
        end

        // R3 load into a full buffer is ignored
        cfg_mode = 2'b00; cfg_encrypt = 1'b1;
        @(negedge clk); blk_load = 1'b1; blk_data = 64'h1111_1111_1111_1111;
        @(negedge clk); blk_data = 64'h2222_2222_2222_2222;
        @(negedge clk); blk_load = 1'b0;
        chk(core_data == 64'h1111_1111_1111_1111, "R3 full ignore", core_data, 64'h1111_1111_1111_1111);

        // R2 context write wins over a same-cycle chaining update
        cfg_mode = 2'b01;
        res_valid = 1'b1; res_data = 64'h3333_3333_3333_3333;
        ctx_we = 1'b1; ctx_data = 64'h5A5A_5A5A_5A5A_5A5A;
        @(negedge clk); res_valid = 1'b0; ctx_we = 1'b0;
        chk(iv_out == 64'h5A5A_5A5A_5A5A_5A5A, "R2 ctx priority", iv_out, 64'h5A5A_5A5A_5A5A_5A5A);
        chk(out_valid && out_data == 64'h3333_3333_3333_3333, "R2 output kept", out_data, 64'h3333_3333_3333_3333);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule